// File: doc/BRIEF.md
# Flash Polling Status Byte Former

This block builds the byte a host sees on each read of a flash array while the embedded program/erase engine is working, paused in an erase suspend, or halted on a failure. Each read strobe carries an address. The block maps the address to an erase block. From the engine state, the block masks and two toggle flip-flops, it then forms a status byte or forwards the array data unchanged.

Software polls the byte to follow progress. Bit 7 tells whether the operation has finished or been suspended. Bit 6 flips on every read while the engine is busy. Bit 5 reports a failure. Bit 3 tells whether a block erase has begun or is still taking more blocks. Bit 2 flips only for reads that land in erasing blocks, or in failed blocks after an erase error, so software can find which block failed. The result is registered and appears one clock after the strobe.

Top module: `poll_status_former`

## Requirements
- R1: After reset `rvalid_o` is 0 and `rdata_o` is 8'h00.
- R2: With state code 0 (idle), a read returns `array_i` unchanged.
- R3: Bit 7 is the inverse of `tgt7_i` in state 1 (program) and state 4 (program failed). It is 0 in state 2 (chip erase), in state 3 (block erase) when not suspended, and in state 5 (erase failed). In state 3 with `susp_i`=1 and the address in an erasing block, bit 7 is 1.
- R4: Bit 6 shows an internal toggle flop that starts at 0 and flips after each read in states 1, 2, 4, 5 and unsuspended state 3. It keeps its value during suspend.
- R5: Bit 5 is 1 in states 4 and 5 and 0 in every other status read.
- R6: Bit 3 is 1 in states 2 and 5. In unsuspended state 3 it equals `win_done_i`. It is 0 in states 1 and 4 and during suspend.
- R7: In states 2 and 3, bit 2 shows a second toggle flop that starts at 0. In state 2 it flips after every read. In state 3 it flips only when the address block bit in `erase_mask_i` is set, whether suspended or not. Bit 2 is 0 in states 1 and 4.
- R8: In state 5, bit 2 shows the second toggle flop, which flips only when the address block bit in `fail_mask_i` is set.
- R9: In state 3 with `susp_i`=1, a read from a block whose `erase_mask_i` bit is clear returns `array_i`, and neither toggle flop advances.
- R10: Bits 4, 1 and 0 are 0 in every status byte.
- R11: `rvalid_o` is high exactly one cycle after `rd_i`. `rdata_o` holds its value in cycles after no strobe.

The block index is the top BW bits of the address. Masks are indexed by block number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_state_i | input | 3 | Engine state: 0 idle, 1 program, 2 chip erase, 3 block erase, 4 program failed, 5 erase failed |
| susp_i | input | 1 | Block erase is suspended |
| win_done_i | input | 1 | Block-append window has expired |
| tgt7_i | input | 1 | Bit 7 of the byte being programmed |
| erase_mask_i | input | NBLK | Blocks selected for erase |
| fail_mask_i | input | NBLK | Blocks that failed to erase |
| rd_i | input | 1 | Read strobe |
| addr_i | input | AW | Read address |
| array_i | input | 8 | Array data at the read address |
| rdata_o | output | 8 | Returned byte |
| rvalid_o | output | 1 | Returned byte valid |

## Verification
The assertions assume that `pe_state_i` holds only codes 0 to 5, and that `susp_i` matters only in state 3. They also assume that `rd_i` is low during reset, so the first history sample after reset is a quiet cycle. The bench drives only the six legal codes and keeps reads one cycle wide with a quiet cycle between them. It sweeps every address under each state, suspend and window combination, using fixed erase and failure masks that cover both inside and outside blocks.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;
  typedef enum logic [2:0] {
    PE_IDLE       = 3'd0,
    PE_PROG       = 3'd1,
    PE_CHIP       = 3'd2,
    PE_BLOCK      = 3'd3,
    PE_PROG_FAIL  = 3'd4,
    PE_ERASE_FAIL = 3'd5
  } pe_state_t;

  localparam int TGL_RUN  = 0;  // bit 6 flop
  localparam int TGL_BLK  = 1;  // bit 2 flop
  localparam int TGL_NUM  = 2;
endpackage

// File: rtl/fps_blk_lookup.sv
module fps_blk_lookup #(
  parameter int AW = 8,
  parameter int BW = 3,
  localparam int NBLK = 1 << BW
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [NBLK-1:0] erase_mask_i,
  input  logic [NBLK-1:0] fail_mask_i,
  output logic            in_erase_o,
  output logic            in_fail_o
);
  logic [BW-1:0] blk;
  assign blk        = addr_i[AW-1 -: BW];
  assign in_erase_o = erase_mask_i[blk];
  assign in_fail_o  = fail_mask_i[blk];
endmodule

// File: rtl/fps_toggle.sv
module fps_toggle (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (adv_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/fps_field_mux.sv
module fps_field_mux
  import poll_status_pkg::*;
(
  input  pe_state_t   state_i,
  input  logic        susp_i,
  input  logic        win_done_i,
  input  logic        tgt7_i,
  input  logic        in_erase_i,
  input  logic        in_fail_i,
  input  logic        t_run_i,
  input  logic        t_blk_i,
  input  logic [7:0]  array_i,
  output logic [7:0]  byte_o,
  output logic        adv_run_o,
  output logic        adv_blk_o
);
  logic show;
  logic b7, b5, b3, b2;

  always_comb begin
    show      = 1'b1;
    b7        = 1'b0;
    b5        = 1'b0;
    b3        = 1'b0;
    b2        = 1'b0;
    adv_run_o = 1'b0;
    adv_blk_o = 1'b0;
    unique case (state_i)
      PE_PROG: begin
        b7        = ~tgt7_i;
        adv_run_o = 1'b1;
      end
      PE_PROG_FAIL: begin
        b7        = ~tgt7_i;
        b5        = 1'b1;
        adv_run_o = 1'b1;
      end
      PE_CHIP: begin
        b3        = 1'b1;
        b2        = t_blk_i;
        adv_run_o = 1'b1;
        adv_blk_o = 1'b1;
      end
      PE_BLOCK: begin
        if (susp_i) begin
          if (in_erase_i) begin
            b7        = 1'b1;
            b2        = t_blk_i;
            adv_blk_o = 1'b1;
          end else begin
            show = 1'b0;
          end
        end else begin
          b3        = win_done_i;
          b2        = t_blk_i;
          adv_run_o = 1'b1;
          adv_blk_o = in_erase_i;
        end
      end
      PE_ERASE_FAIL: begin
        b5        = 1'b1;
        b3        = 1'b1;
        b2        = t_blk_i;
        adv_run_o = 1'b1;
        adv_blk_o = in_fail_i;
      end
      default: show = 1'b0;
    endcase
    byte_o = show ? {b7, t_run_i, b5, 1'b0, b3, b2, 2'b00} : array_i;
    if (!show) begin
      adv_run_o = 1'b0;
      adv_blk_o = 1'b0;
    end
  end
endmodule

// File: rtl/poll_status_former.sv
module poll_status_former
  import poll_status_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 3,
  localparam int NBLK = 1 << BW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      pe_state_i,
  input  logic            susp_i,
  input  logic            win_done_i,
  input  logic            tgt7_i,
  input  logic [NBLK-1:0] erase_mask_i,
  input  logic [NBLK-1:0] fail_mask_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      array_i,
  output logic [7:0]      rdata_o,
  output logic            rvalid_o
);
  logic               in_erase, in_fail;
  logic [TGL_NUM-1:0] tq, adv_raw, adv;
  logic [7:0]         next_byte;

  fps_blk_lookup #(.AW(AW), .BW(BW)) u_lookup (
    .addr_i       (addr_i),
    .erase_mask_i (erase_mask_i),
    .fail_mask_i  (fail_mask_i),
    .in_erase_o   (in_erase),
    .in_fail_o    (in_fail)
  );

  fps_field_mux u_mux (
    .state_i    (pe_state_t'(pe_state_i)),
    .susp_i     (susp_i),
    .win_done_i (win_done_i),
    .tgt7_i     (tgt7_i),
    .in_erase_i (in_erase),
    .in_fail_i  (in_fail),
    .t_run_i    (tq[TGL_RUN]),
    .t_blk_i    (tq[TGL_BLK]),
    .array_i    (array_i),
    .byte_o     (next_byte),
    .adv_run_o  (adv_raw[TGL_RUN]),
    .adv_blk_o  (adv_raw[TGL_BLK])
  );

  for (genvar g = 0; g < TGL_NUM; g++) begin : g_tgl
    assign adv[g] = rd_i & adv_raw[g];
    fps_toggle u_tgl (
      .clk   (clk),
      .rst   (rst),
      .adv_i (adv[g]),
      .q_o   (tq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= 8'h00;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= next_byte;
    end
  end
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk #(
  parameter int AW = 8,
  parameter int BW = 3,
  localparam int NBLK = 1 << BW
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      pe_state_i,
  input logic            susp_i,
  input logic            tgt7_i,
  input logic            rd_i,
  input logic [7:0]      array_i,
  input logic [7:0]      rdata_o,
  input logic            rvalid_o
);
  logic prog_rd;
  assign prog_rd = rd_i && (pe_state_i == 3'd1);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (rd_i && pe_state_i == 3'd0) |=> rdata_o == $past(array_i)); // R2
  AST_PROG_INV7: assert property (@(posedge clk) disable iff (rst)
    prog_rd |=> rdata_o[7] == !$past(tgt7_i)); // R3
  AST_RUN_FLIP: assert property (@(posedge clk) disable iff (rst)
    (prog_rd && $past(prog_rd)) |=> rdata_o[6] != $past(rdata_o[6])); // R4
  AST_FAIL_BIT: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (pe_state_i == 3'd4 || pe_state_i == 3'd5)) |=> rdata_o[5]); // R5
  AST_CHIP_STARTED: assert property (@(posedge clk) disable iff (rst)
    (rd_i && pe_state_i == 3'd2) |=> rdata_o[3]); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && pe_state_i != 3'd0 && !(pe_state_i == 3'd3 && susp_i))
      |=> (rdata_o[4] == 1'b0 && rdata_o[1:0] == 2'b00)); // R10
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rvalid_o); // R11
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (!rvalid_o && $stable(rdata_o))); // R11
endmodule

bind poll_status_former poll_status_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pe_state_i (pe_state_i),
  .susp_i     (susp_i),
  .tgt7_i     (tgt7_i),
  .rd_i       (rd_i),
  .array_i    (array_i),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/sim_poll_status_former.sv
module sim_poll_status_former;
  localparam int AW = 8;
  localparam int BW = 3;
  localparam int NBLK = 1 << BW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      pe_state_i = '0;
  logic            susp_i = 1'b0;
  logic            win_done_i = 1'b0;
  logic            tgt7_i = 1'b0;
  logic [NBLK-1:0] erase_mask_i = 8'b1010_0101;
  logic [NBLK-1:0] fail_mask_i  = 8'b0010_0100;
  logic            rd_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [7:0]      array_i = '0;
  logic [7:0]      rdata_o;
  logic            rvalid_o;

  int checks = 0;
  int errors = 0;
  logic m6 = 1'b0;
  logic m2 = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  poll_status_former #(.AW(AW), .BW(BW)) u0 (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    logic [BW-1:0] b;
    logic ie, ifl, show, a6, a2;
    logic e7, e5, e3, e2;
    @(negedge clk);
    addr_i  = a;
    array_i = a ^ 8'h5A;
    tgt7_i  = a[0];
    rd_i    = 1'b1;
    b   = a[AW-1 -: BW];
    ie  = erase_mask_i[b];
    ifl = fail_mask_i[b];
    show = 1'b1; a6 = 1'b0; a2 = 1'b0;
    e7 = 1'b0; e5 = 1'b0; e3 = 1'b0; e2 = 1'b0;
    case (pe_state_i)
      3'd1: begin e7 = ~a[0]; a6 = 1'b1; end
      3'd4: begin e7 = ~a[0]; e5 = 1'b1; a6 = 1'b1; end
      3'd2: begin e3 = 1'b1; e2 = m2; a6 = 1'b1; a2 = 1'b1; end
      3'd3: if (susp_i) begin
              if (ie) begin e7 = 1'b1; e2 = m2; a2 = 1'b1; end
              else show = 1'b0;
            end else begin
              e3 = win_done_i; e2 = m2; a6 = 1'b1; a2 = ie;
            end
      3'd5: begin e5 = 1'b1; e3 = 1'b1; e2 = m2; a6 = 1'b1; a2 = ifl; end
      default: show = 1'b0;
    endcase
    @(negedge clk);
    rd_i = 1'b0;
    chk("R11 rvalid", {7'd0, rvalid_o}, 8'd1);
    if (!show) begin
      if (pe_state_i == 3'd0) chk("R2 idle pass", rdata_o, array_i);
      else                    chk("R9 suspend pass", rdata_o, array_i);
    end else begin
      chk("R3 bit7", {7'd0, rdata_o[7]}, {7'd0, e7});
      chk("R4 bit6", {7'd0, rdata_o[6]}, {7'd0, m6});
      chk("R5 bit5", {7'd0, rdata_o[5]}, {7'd0, e5});
      chk("R6 bit3", {7'd0, rdata_o[3]}, {7'd0, e3});
      if (pe_state_i == 3'd5) chk("R8 bit2", {7'd0, rdata_o[2]}, {7'd0, e2});
      else                    chk("R7 bit2", {7'd0, rdata_o[2]}, {7'd0, e2});
      chk("R10 spare", {5'd0, rdata_o[4], rdata_o[1:0]}, 8'd0);
    end
    if (a6) m6 = ~m6;
    if (a2) m2 = ~m2;
    begin
      logic [7:0] held;
      held = rdata_o;
      @(negedge clk);
      chk("R11 hold", rdata_o, held);
      chk("R11 idle valid", {7'd0, rvalid_o}, 8'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset data", rdata_o, 8'h00);
    chk("R1 reset valid", {7'd0, rvalid_o}, 8'd0);
    rst = 1'b0;
    for (int s = 0; s < 6; s++) begin
      for (int sp = 0; sp < 2; sp++) begin
        for (int w = 0; w < 2; w++) begin
          @(negedge clk);
          pe_state_i = 3'(s);
          susp_i     = sp[0];
          win_done_i = w[0];
          for (int a = 0; a < (1 << AW); a++) do_read(AW'(a));
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule